// File: doc/BRIEF.md
# Staged Pipeline Control Decoder

This block sits beside the decode stage of a five-stage in-order integer pipeline. It reads the 6-bit major opcode of the instruction held in the fetch/decode register and works out, in one place, every control signal the downstream datapath needs. Those signals are then carried forward in three control registers that sit alongside the datapath's own pipeline registers. Execute, memory and write-back each see only the group of signals they use, and each group is aligned with the instruction that stage is working on.

Four instruction classes are recognised: register-register arithmetic, word load, word store and branch-if-equal. Any other opcode produces an all-zero control word. That word behaves as a bubble, because it issues no memory access and no register write. A synchronous reset clears all three control registers. One flush input per register replaces the word being captured with zeros, so the datapath can cancel an instruction at the stage where a hazard or redirect is found.

Top module: `ctl_stage_top`

## Requirements
- R1: Opcode 6'h00 (register-register) yields reg_dst=1, alu_op=2'b10, alu_src=0, branch=0, mem_read=0, mem_write=0, reg_write=1, mem_to_reg=0.
- R2: Opcode 6'h23 (word load) yields reg_dst=0, alu_op=2'b00, alu_src=1, branch=0, mem_read=1, mem_write=0, reg_write=1, mem_to_reg=1.
- R3: Opcode 6'h2B (word store) yields alu_op=2'b00, alu_src=1, mem_write=1, and zero in every other field, including the two fields whose value does not matter for a store (reg_dst, mem_to_reg). mem_read and mem_write are never both 1.
- R4: Opcode 6'h04 (branch-if-equal) yields alu_op=2'b01, branch=1, and zero in every other field.
- R5: Any other opcode yields all-zero controls. Only instr[31:26] affects the result.
- R6: The execute group (reg_dst, alu_op, alu_src) of an instruction presented on instr appears at the outputs after exactly one rising edge.
- R7: The memory group (branch, mem_read, mem_write) of that instruction appears after exactly two rising edges.
- R8: The write-back group (reg_write, mem_to_reg) of that instruction appears after exactly three rising edges.
- R9: A rising edge with rst=1 clears all three control registers, so every output is 0 after it.
- R10: flush_ex=1 at an edge loads zeros into the decode/execute control register. The instruction being captured then produces no control in any later stage.
- R11: flush_mem=1 at an edge loads zeros into the execute/memory control register. This removes that instruction's memory group and its write-back group.
- R12: flush_wb=1 at an edge loads zeros into the memory/write-back control register.
- R13: Each flush input clears only its own register. The other stages keep advancing unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word from the fetch/decode register |
| flush_ex | input | 1 | Zero the decode/execute control register at this edge |
| flush_mem | input | 1 | Zero the execute/memory control register at this edge |
| flush_wb | input | 1 | Zero the memory/write-back control register at this edge |
| ex_reg_dst | output | 1 | Execute: pick rd (1) or rt (0) as destination |
| ex_alu_op | output | 2 | Execute: ALU class (00 add, 01 subtract, 10 function field) |
| ex_alu_src | output | 1 | Execute: second ALU operand is the immediate |
| mem_branch | output | 1 | Memory: instruction is a conditional branch |
| mem_read | output | 1 | Memory: data memory read |
| mem_write | output | 1 | Memory: data memory write |
| wb_reg_write | output | 1 | Write-back: register file write |
| wb_mem_to_reg | output | 1 | Write-back: result comes from memory |

## Verification
A fault in the decode logic shows on the execute outputs one edge after the opcode is applied. The same bad value then moves to the memory and write-back outputs one and two edges later. A fault in a control register, such as a slip, a missed flush or a leftover value after reset, appears only at the stage that register feeds, one edge after the cause. Mixed streams of valid and invalid opcodes are walked back to back, so a group that goes to the wrong stage or arrives a cycle early or late is caught at the first mismatched stage. Flushes are applied while neighbouring stages hold real instructions, so a flush that clears too much or too little also shows up.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_class_e;

    typedef struct packed {
        logic       reg_dst;
        alu_class_e alu_op;
        logic       alu_src;
    } ex_grp_t;

    typedef struct packed {
        logic branch;
        logic rd;
        logic wr;
    } mem_grp_t;

    typedef struct packed {
        logic reg_write;
        logic mem_to_reg;
    } wb_grp_t;

    // word held by decode/execute register
    typedef struct packed {
        ex_grp_t  ex;
        mem_grp_t mem;
        wb_grp_t  wb;
    } idex_word_t;

    // word held by execute/memory register
    typedef struct packed {
        mem_grp_t mem;
        wb_grp_t  wb;
    } exmem_word_t;

    // word held by memory/write-back register
    typedef struct packed {
        wb_grp_t wb;
    } memwb_word_t;

    function automatic idex_word_t decode_opcode(input logic [OPC_W-1:0] opc);
        idex_word_t w;
        w = '0;
        case (opc)
            OPC_RTYPE: begin
                w.ex.reg_dst    = 1'b1;
                w.ex.alu_op     = ALU_FUNCT;
                w.wb.reg_write  = 1'b1;
            end
            OPC_LOAD: begin
                w.ex.alu_op     = ALU_ADD;
                w.ex.alu_src    = 1'b1;
                w.mem.rd        = 1'b1;
                w.wb.reg_write  = 1'b1;
                w.wb.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                w.ex.alu_op     = ALU_ADD;
                w.ex.alu_src    = 1'b1;
                w.mem.wr        = 1'b1;
            end
            OPC_BEQ: begin
                w.ex.alu_op     = ALU_SUB;
                w.mem.branch    = 1'b1;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output idex_word_t       ctl
);

    always_comb begin
        ctl = decode_opcode(opcode);
    end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ctl_stage_top.sv
module ctl_stage_top
    import ctl_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               flush_ex,
    input  logic               flush_mem,
    input  logic               flush_wb,
    output logic               ex_reg_dst,
    output logic [1:0]         ex_alu_op,
    output logic               ex_alu_src,
    output logic               mem_branch,
    output logic               mem_read,
    output logic               mem_write,
    output logic               wb_reg_write,
    output logic               wb_mem_to_reg
);

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int IDEX_W  = $bits(idex_word_t);
    localparam int EXMEM_W = $bits(exmem_word_t);
    localparam int MEMWB_W = $bits(memwb_word_t);

    logic        unused_low_bits;
    idex_word_t  dec_ctl;
    idex_word_t  idex_q;
    exmem_word_t exmem_d, exmem_q;
    memwb_word_t memwb_d, memwb_q;
    logic [IDEX_W-1:0]  idex_raw;
    logic [EXMEM_W-1:0] exmem_raw;
    logic [MEMWB_W-1:0] memwb_raw;

    assign unused_low_bits = ^instr[OPC_LSB-1:0];

    ctl_decode u_decode (
        .opcode (instr[INSTR_W-1:OPC_LSB]),
        .ctl    (dec_ctl)
    );

    ctl_stage_reg #(.W(IDEX_W)) u_idex (
        .clk (clk),
        .rst (rst),
        .clr (flush_ex),
        .d   (dec_ctl),
        .q   (idex_raw)
    );
    assign idex_q = idex_word_t'(idex_raw);

    assign exmem_d.mem = idex_q.mem;
    assign exmem_d.wb  = idex_q.wb;

    ctl_stage_reg #(.W(EXMEM_W)) u_exmem (
        .clk (clk),
        .rst (rst),
        .clr (flush_mem),
        .d   (exmem_d),
        .q   (exmem_raw)
    );
    assign exmem_q = exmem_word_t'(exmem_raw);

    assign memwb_d.wb = exmem_q.wb;

    ctl_stage_reg #(.W(MEMWB_W)) u_memwb (
        .clk (clk),
        .rst (rst),
        .clr (flush_wb),
        .d   (memwb_d),
        .q   (memwb_raw)
    );
    assign memwb_q = memwb_word_t'(memwb_raw);

    assign ex_reg_dst    = idex_q.ex.reg_dst;
    assign ex_alu_op     = idex_q.ex.alu_op;
    assign ex_alu_src    = idex_q.ex.alu_src;
    assign mem_branch    = exmem_q.mem.branch;
    assign mem_read      = exmem_q.mem.rd;
    assign mem_write     = exmem_q.mem.wr;
    assign wb_reg_write  = memwb_q.wb.reg_write;
    assign wb_mem_to_reg = memwb_q.wb.mem_to_reg;

    // R9: reset clears every stage
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> ({ex_reg_dst, ex_alu_op, ex_alu_src, mem_branch, mem_read,
                  mem_write, wb_reg_write, wb_mem_to_reg} == '0));

    // R3: a memory stage never reads and writes at once
    assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));

    // R10: a flushed decode/execute capture carries nothing forward
    assert_ex_flush_R10: assert property (@(posedge clk) disable iff (rst)
        flush_ex |=> (idex_q == '0));

    // R7: memory group moves one stage when not flushed
    assert_mem_follow_R7: assert property (@(posedge clk) disable iff (rst)
        !flush_mem |=> ({mem_branch, mem_read, mem_write} == $past(idex_q.mem)));

    // R8: write-back group moves one stage when not flushed
    assert_wb_follow_R8: assert property (@(posedge clk) disable iff (rst)
        !flush_wb |=> ({wb_reg_write, wb_mem_to_reg} == $past(exmem_q.wb)));

    // R12: a flushed write-back register issues no register write
    assert_wb_flush_R12: assert property (@(posedge clk) disable iff (rst)
        flush_wb |=> !wb_reg_write);

endmodule

// File: tb/ctl_stage_top_bench.sv
module ctl_stage_top_bench;

    localparam int N_VEC = 14;
    // {opcode[5:0], expected {reg_dst, alu_op[1:0], alu_src, branch, mem_read, mem_write, reg_write, mem_to_reg}}
    localparam logic [14:0] VEC [0:N_VEC-1] = '{
        {6'h00, 9'b1_10_0_000_10},   // R1
        {6'h23, 9'b0_00_1_010_11},   // R2
        {6'h2B, 9'b0_00_1_001_00},   // R3
        {6'h04, 9'b0_01_0_100_00},   // R4
        {6'h3F, 9'b0_00_0_000_00},   // R5
        {6'h00, 9'b1_10_0_000_10},
        {6'h05, 9'b0_00_0_000_00},   // R5
        {6'h23, 9'b0_00_1_010_11},
        {6'h23, 9'b0_00_1_010_11},
        {6'h08, 9'b0_00_0_000_00},   // R5
        {6'h04, 9'b0_01_0_100_00},
        {6'h2B, 9'b0_00_1_001_00},
        {6'h3F, 9'b0_00_0_000_00},
        {6'h3F, 9'b0_00_0_000_00}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        flush_ex, flush_mem, flush_wb;
    logic        ex_reg_dst, ex_alu_src, mem_branch, mem_read, mem_write;
    logic        wb_reg_write, wb_mem_to_reg;
    logic [1:0]  ex_alu_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ctl_stage_top u_ctl_stage_top (
        .clk           (clk),
        .rst           (rst),
        .instr         (instr),
        .flush_ex      (flush_ex),
        .flush_mem     (flush_mem),
        .flush_wb      (flush_wb),
        .ex_reg_dst    (ex_reg_dst),
        .ex_alu_op     (ex_alu_op),
        .ex_alu_src    (ex_alu_src),
        .mem_branch    (mem_branch),
        .mem_read      (mem_read),
        .mem_write     (mem_write),
        .wb_reg_write  (wb_reg_write),
        .wb_mem_to_reg (wb_mem_to_reg)
    );

    function automatic logic [3:0] ex_now();
        return {ex_reg_dst, ex_alu_op, ex_alu_src};
    endfunction
    function automatic logic [2:0] mem_now();
        return {mem_branch, mem_read, mem_write};
    endfunction
    function automatic logic [1:0] wb_now();
        return {wb_reg_write, wb_mem_to_reg};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [5:0] opc, input logic [25:0] low);
        instr = {opc, low};
    endtask

    initial begin
        rst = 1'b1; flush_ex = 1'b0; flush_mem = 1'b0; flush_wb = 1'b0;
        instr = {6'h23, 26'h0};
        @(negedge clk);
        step(); step(); step();
        // R9: reset state with a load presented
        check("R9", {ex_now(), mem_now(), wb_now()}, 9'b0);
        rst = 1'b0;

        // vector walk: R1..R8
        for (int i = 0; i < N_VEC; i++) begin
            drive(VEC[i][14:9], 26'(i * 32'h0137_1A5));
            step();
            check($sformatf("R6 vec%0d", i), {5'b0, ex_now()}, {5'b0, VEC[i][8:5]});
            if (i >= 1)
                check($sformatf("R7 vec%0d", i), {6'b0, mem_now()}, {6'b0, VEC[i-1][4:2]});
            if (i >= 2)
                check($sformatf("R8 vec%0d", i), {7'b0, wb_now()}, {7'b0, VEC[i-2][1:0]});
        end

        // R5: low bits do not matter for an unknown opcode
        drive(6'h3E, 26'h3FF_FFFF);
        step();
        check("R5 low bits", {5'b0, ex_now()}, 9'b0);

        // R9: reset in the middle of a stream
        drive(6'h23, 26'h0); step();
        drive(6'h00, 26'h0); step();
        rst = 1'b1; step(); rst = 1'b0;
        check("R9 mid", {ex_now(), mem_now(), wb_now()}, 9'b0);

        // R10 / R13: flush_ex kills the load, store keeps advancing
        drive(6'h2B, 26'h1); step();
        drive(6'h23, 26'h2); flush_ex = 1'b1; step(); flush_ex = 1'b0;
        check("R10 ex", {5'b0, ex_now()}, 9'b0);
        check("R13 mem kept", {6'b0, mem_now()}, 9'b001);
        drive(6'h3F, 26'h0); step();
        check("R10 mem", {6'b0, mem_now()}, 9'b0);
        step();
        check("R10 wb", {7'b0, wb_now()}, 9'b0);

        // R11 / R13: flush_mem kills R-type mem and wb, beq keeps going
        drive(6'h00, 26'h3); step();
        drive(6'h04, 26'h4); flush_mem = 1'b1; step(); flush_mem = 1'b0;
        check("R11 mem", {6'b0, mem_now()}, 9'b0);
        check("R13 ex kept", {5'b0, ex_now()}, 9'b0_0000_0010);
        drive(6'h3F, 26'h0); step();
        check("R11 wb", {7'b0, wb_now()}, 9'b0);
        check("R13 mem beq", {6'b0, mem_now()}, 9'b100);

        // R12: flush_wb kills a load's register write
        drive(6'h23, 26'h5); step();
        drive(6'h3F, 26'h0); step();
        check("R12 mem lw", {6'b0, mem_now()}, 9'b010);
        flush_wb = 1'b1; step(); flush_wb = 1'b0;
        check("R12 wb", {7'b0, wb_now()}, 9'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule